// File: doc/BRIEF.md
# Inter-processor software interrupt controller

This block lets a small group of harts interrupt one another. It holds one shared 32-bit pending word. Each hart owns an 8-bit slice of that word as a sender. Inside a slice, the bit position selects the target hart in reverse order. A sender raises an interrupt by writing a 1 to the bit that names the target. Each target hart has its own enable word, normally programmed so that it sees exactly one bit in every sender's slice. Each source also has a priority register.

A hart with an interrupt waiting reads its claim register. The read returns the best waiting source and clears the pending bit. While the hart services the source, that source is held back from it. Writing the same source ID back to the claim register completes the interrupt. Every register is reached through a simple 32-bit register bus. Reads are combinational on the address. The read strobe carries the side effect of a claim. There is one level-sensitive interrupt line per hart.

Top module: `ipi_softirq_ctrl`

## Requirements
- R1: After reset the pending word, every enable word, every priority register and every interrupt line are zero, and a claim read returns 0.
- R2: Writing to the pending word at address 0x1000 sets each bit written as 1 and leaves every bit written as 0 unchanged. Bits that name no existing hart (bits 0 to 3 of each byte with four harts) ignore writes and always read 0.
- R3: The pending bit for sender s and target t is bit 8*s + 7 - t. The source ID of a pending bit is its bit index.
- R4: The priority register of source ID k (1 to 31) sits at address 4*k. It is 3 bits wide and reads back zero-extended. Address 0 is source 0, which reads 0 and ignores writes.
- R5: The enable word of hart h sits at address 0x2000 + 0x80*h. It is 32 bits wide and can be written and read back in full.
- R6: Line irq_o[h] is high exactly when some source is pending, enabled for hart h, has nonzero priority and is not in flight for hart h.
- R7: A read with re_i at the claim address 0x200004 + 0x1000*h returns the eligible source of highest priority. A tie goes to the lowest ID. The read returns 0 when no source is eligible.
- R8: A claim that returns a nonzero ID clears that pending bit and marks the source in flight for the claiming hart. A source in flight is not presented to that hart again, even if it is pended again.
- R9: Writing an ID to a hart's claim address releases that source if it is in flight for that hart. A write of an ID that is not in flight has no effect.
- R10: A pending, enabled source with priority 0 raises no interrupt and is never returned by a claim, and its pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 22 | Register byte address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; performs the claim at claim addresses |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 4 | Interrupt line per hart |

## Verification
The assertions assume the following about the inputs:
- Accesses are word aligned.
- Only one access occurs per cycle, so a pending write and a claim can never meet in one cycle.
- re_i and we_i are never raised together at a claim address.

The bench keeps within these assumptions. It drives one task-based access at a time, with the strobes dropped between accesses. It sweeps every sender and target pair, and it computes the expected claim order from the programmed priorities.

// File: rtl/ipi_ctrl_pkg.sv
package ipi_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  // Bits of the pending word that name an existing target hart.
  function automatic logic [DATA_W-1:0] live_mask(int unsigned harts, int unsigned region_w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int s = 0; s < int'(harts); s++)
      for (int t = 0; t < int'(harts); t++)
        m[s*int'(region_w) + int'(region_w) - 1 - t] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ipi_pend_array.sv
module ipi_pend_array #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ID_W = 5,
  parameter logic [NUM_SRC-1:0] LIVE = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [NUM_SRC-1:0] set_bits_i,
  input  logic               clr_en_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d, set_vec, clr_vec;
  logic upd;

  always_comb begin
    set_vec = set_en_i ? (set_bits_i & LIVE) : '0;
    clr_vec = clr_en_i ? (NUM_SRC'(1) << clr_id_i) : '0;
    // a set in the same cycle as a claim clear wins
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    upd     = set_en_i | clr_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ipi_claim_arbiter.sv
module ipi_claim_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W = 5
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]                id_o
);
  logic [PRIO_W-1:0] best_p;

  // walk downward so that on equal priority the lower ID replaces the higher
  always_comb begin
    best_p = '0;
    id_o   = '0;
    for (int i = int'(NUM_SRC) - 1; i >= 1; i--) begin
      if (cand_i[i] && (prio_i[i] >= best_p)) begin
        best_p = prio_i[i];
        id_o   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/ipi_flight_track.sv
module ipi_flight_track #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ID_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_en_i,
  input  logic [ID_W-1:0]    take_id_i,
  input  logic               done_en_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [NUM_SRC-1:0] busy_o
);
  logic [NUM_SRC-1:0] busy_q, busy_d, take_vec, done_vec;
  logic upd;

  always_comb begin
    take_vec = take_en_i ? (NUM_SRC'(1) << take_id_i) : '0;
    done_vec = done_en_i ? (NUM_SRC'(1) << done_id_i) : '0;
    // releasing a source that is not busy clears a zero bit: no effect
    busy_d   = (busy_q | take_vec) & ~done_vec;
    upd      = take_en_i | done_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  busy_q <= '0;
    else if (upd) busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ipi_softirq_ctrl.sv
module ipi_softirq_ctrl
  import ipi_ctrl_pkg::*;
#(
  parameter int unsigned NUM_HARTS    = 4,
  parameter int unsigned REGION_W     = 8,
  parameter int unsigned PRIO_W       = 3,
  parameter int unsigned ADDR_W       = 22,
  parameter int unsigned PEND_OFF     = 32'h1000,
  parameter int unsigned EN_OFF       = 32'h2000,
  parameter int unsigned EN_STRIDE    = 32'h80,
  parameter int unsigned CLAIM_OFF    = 32'h200004,
  parameter int unsigned CLAIM_STRIDE = 32'h1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int unsigned NUM_SRC = NUM_HARTS * REGION_W;
  localparam int unsigned ID_W    = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] LIVE = NUM_SRC'(live_mask(NUM_HARTS, REGION_W));

  // ---------------- address decode ----------------
  logic                 prio_hit, pend_hit;
  logic [ID_W-1:0]      prio_idx;
  logic [NUM_HARTS-1:0] en_hit, claim_hit;

  always_comb begin
    prio_hit = (addr_i < ADDR_W'(4 * NUM_SRC)) && (addr_i[1:0] == 2'b00);
    prio_idx = addr_i[2 +: ID_W];
    pend_hit = (addr_i == ADDR_W'(PEND_OFF));
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_dec
    assign en_hit[h]    = (addr_i == ADDR_W'(EN_OFF + h * EN_STRIDE));
    assign claim_hit[h] = (addr_i == ADDR_W'(CLAIM_OFF + h * CLAIM_STRIDE));
  end

  // ---------------- priority registers ----------------
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic                           prio_we;
  logic [NUM_SRC-1:0]             prio_nz;

  always_comb begin
    prio_we = we_i && prio_hit && (prio_idx != '0);
    prio_d  = prio_q;
    prio_d[prio_idx] = wdata_i[PRIO_W-1:0];
    for (int i = 0; i < int'(NUM_SRC); i++) prio_nz[i] = (prio_q[i] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prio_q <= '0;
    else if (prio_we) prio_q <= prio_d;
  end

  // ---------------- enable words ----------------
  logic [NUM_HARTS-1:0][NUM_SRC-1:0] en_q;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_en
    logic en_we;
    assign en_we = we_i && en_hit[h];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q[h] <= '0;
      else if (en_we) en_q[h] <= wdata_i[NUM_SRC-1:0];
    end
  end

  // ---------------- pending word ----------------
  logic [NUM_SRC-1:0]   pend;
  logic                 pend_set;
  logic                 clr_en;
  logic [ID_W-1:0]      clr_id;
  logic [NUM_HARTS-1:0] claim_fire;
  logic [NUM_HARTS-1:0][ID_W-1:0] best_id;

  assign pend_set = we_i && pend_hit;

  always_comb begin
    clr_en = |claim_fire;
    clr_id = '0;
    for (int h = 0; h < int'(NUM_HARTS); h++)
      if (claim_fire[h]) clr_id = best_id[h];
  end

  ipi_pend_array #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .LIVE(LIVE)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (pend_set),
    .set_bits_i (wdata_i[NUM_SRC-1:0]),
    .clr_en_i   (clr_en),
    .clr_id_i   (clr_id),
    .pend_o     (pend)
  );

  // ---------------- per-hart claim path ----------------
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic [NUM_SRC-1:0] busy, cand;
    logic               done_en;

    assign cand        = pend & en_q[h] & prio_nz & ~busy;
    assign irq_o[h]    = |cand;
    assign claim_fire[h] = re_i && claim_hit[h] && (best_id[h] != '0);
    assign done_en     = we_i && claim_hit[h] && (wdata_i[DATA_W-1:ID_W] == '0);

    ipi_claim_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand_i (cand),
      .prio_i (prio_q),
      .id_o   (best_id[h])
    );

    ipi_flight_track #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_en_i (claim_fire[h]),
      .take_id_i (best_id[h]),
      .done_en_i (done_en),
      .done_id_i (wdata_i[ID_W-1:0]),
      .busy_o    (busy)
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata_o = '0;
    if (prio_hit) rdata_o = DATA_W'(prio_q[prio_idx]);
    if (pend_hit) rdata_o = DATA_W'(pend);
    for (int h = 0; h < int'(NUM_HARTS); h++) begin
      if (en_hit[h])    rdata_o = DATA_W'(en_q[h]);
      if (claim_hit[h]) rdata_o = DATA_W'(best_id[h]);
    end
  end
endmodule

// File: rtl/ipi_softirq_checker.sv
module ipi_softirq_checker #(
  parameter int unsigned NUM_HARTS    = 4,
  parameter int unsigned REGION_W     = 8,
  parameter int unsigned ADDR_W       = 22,
  parameter int unsigned PEND_OFF     = 32'h1000,
  parameter int unsigned CLAIM_OFF    = 32'h200004,
  parameter int unsigned CLAIM_STRIDE = 32'h1000
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              addr_i,
  input logic                           we_i,
  input logic                           re_i,
  input logic [31:0]                    wdata_i,
  input logic [31:0]                    rdata_i,
  input logic [NUM_HARTS-1:0]           irq_i,
  input logic [NUM_HARTS*REGION_W-1:0]  pend_i
);
  localparam int unsigned NUM_SRC = NUM_HARTS * REGION_W;
  localparam int unsigned ID_W    = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] LIVE = NUM_SRC'(ipi_ctrl_pkg::live_mask(NUM_HARTS, REGION_W));

  logic [NUM_HARTS-1:0] at_claim;
  logic                 claim_any, pend_wr;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_addr
    assign at_claim[h] = (addr_i == ADDR_W'(CLAIM_OFF + h * CLAIM_STRIDE));
  end
  assign claim_any = re_i && (|at_claim) && (rdata_i != '0);
  assign pend_wr   = we_i && (addr_i == ADDR_W'(PEND_OFF));

  // R2: only bits naming an existing hart can ever be pending
  assert_dead_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i & ~LIVE) == '0);

  // R2: a write of ones to the pending word sets those live bits
  assert_w1s_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr |=> ((pend_i & $past(wdata_i[NUM_SRC-1:0] & LIVE)) == $past(wdata_i[NUM_SRC-1:0] & LIVE)));

  // R8: a successful claim clears the claimed pending bit
  assert_claim_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_any |=> !pend_i[$past(rdata_i[ID_W-1:0])]);

  for (genvar b = 1; b < NUM_SRC; b++) begin : g_bit
    // R8: a pending bit only falls through a claim that returned it
    assert_fall_by_claim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_i[b]) |-> $past(claim_any && (rdata_i[ID_W-1:0] == ID_W'(b))));
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
    // R7: a claim returns a source exactly when the hart's line is raised
    assert_claim_matches_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && at_claim[h]) |-> ((rdata_i != '0) == irq_i[h]));
  end
endmodule

bind ipi_softirq_ctrl ipi_softirq_checker #(
  .NUM_HARTS(NUM_HARTS), .REGION_W(REGION_W), .ADDR_W(ADDR_W),
  .PEND_OFF(PEND_OFF), .CLAIM_OFF(CLAIM_OFF), .CLAIM_STRIDE(CLAIM_STRIDE)
) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
  .wdata_i(wdata_i), .rdata_i(rdata_o), .irq_i(irq_o), .pend_i(pend)
);

// File: tb/test_ipi_softirq_ctrl.sv
`timescale 1ns/1ps
module test_ipi_softirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] addr;
  logic        we, re;
  logic [31:0] wdata, rdata;
  logic [3:0]  irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  ipi_softirq_ctrl i_ipi_softirq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [21:0] a_prio(int k);  return 22'(4 * k); endfunction
  function automatic logic [21:0] a_en(int h);    return 22'(32'h2000 + 32'h80 * h); endfunction
  function automatic logic [21:0] a_claim(int h); return 22'(32'h200004 + 32'h1000 * h); endfunction
  localparam logic [21:0] A_PEND = 22'h1000;

  function automatic logic [31:0] pbit(int s, int t); return 32'(1) << (8 * s + 7 - t); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1; we = 1'b0;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int pr [32];
    logic [31:0] left;
    rst_n = 1'b0; addr = '0; we = 0; re = 0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", 32'(irq), 32'd0);
    rd(A_PEND, d);     check("R1 pending", d, 0);
    rd(a_en(2), d);    check("R1 enable", d, 0);
    rd(a_prio(9), d);  check("R1 priority", d, 0);
    rd(a_claim(0), d); check("R1 claim", d, 0);

    // R4 / R5 programming and readback
    for (int k = 0; k < 32; k++) begin wr(a_prio(k), 32'd1); pr[k] = (k == 0) ? 0 : 1; end
    rd(a_prio(0), d);  check("R4 source0 reads 0", d, 0);
    rd(a_prio(31), d); check("R4 priority readback", d, 1);
    wr(a_prio(5), 32'hFF); rd(a_prio(5), d); check("R4 width 3", d, 32'h7);
    wr(a_prio(5), 32'd1);
    for (int h = 0; h < 4; h++) begin
      wr(a_en(h), 32'h80808080 >> h);
      rd(a_en(h), d); check("R5 enable readback", d, 32'h80808080 >> h);
    end

    // R2 dead bits ignored
    wr(A_PEND, 32'h0F0F0F0F);
    rd(A_PEND, d); check("R2 dead bits", d, 0);
    #1 check("R2 no irq", 32'(irq), 0);

    // R3/R6/R7/R8/R9 full sender x target sweep
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        wr(A_PEND, pbit(s, t));
        rd(A_PEND, d); check("R3 pending bit", d, pbit(s, t));
        check("R6 irq target", 32'(irq), 32'(1) << t);
        rd(a_claim((t + 1) % 4), d); check("R7 other hart claims 0", d, 0);
        rd(a_claim(t), d); check("R3 claim id", d, 32'(8 * s + 7 - t));
        rd(A_PEND, d); check("R8 claim clears", d, 0);
        check("R6 irq low after claim", 32'(irq), 0);
        wr(a_claim(t), 32'(8 * s + 7 - t));
      end
    end

    // R2 writing zeros leaves bits
    wr(A_PEND, pbit(1, 2)); wr(A_PEND, 32'd0);
    rd(A_PEND, d); check("R2 zero write no effect", d, pbit(1, 2));
    rd(a_claim(2), d); wr(a_claim(2), d);

    // R7 priority order with tie, targets of hart 0
    wr(a_prio(7), 2);  pr[7] = 2;
    wr(a_prio(15), 5); pr[15] = 5;
    wr(a_prio(23), 5); pr[23] = 5;
    wr(a_prio(31), 1); pr[31] = 1;
    wr(A_PEND, 32'h80808080);
    left = 32'h80808080;
    for (int n = 0; n < 4; n++) begin
      int best, bp;
      best = 0; bp = 0;
      for (int k = 31; k >= 1; k--)
        if (left[k] && pr[k] >= bp) begin best = k; bp = pr[k]; end
      left[best] = 1'b0;
      rd(a_claim(0), d); check("R7 priority order", d, 32'(best));
      wr(a_claim(0), d);
    end
    rd(a_claim(0), d); check("R7 empty claim", d, 0);

    // R10 zero priority
    wr(a_prio(7), 0);
    wr(A_PEND, 32'h80);
    #1 check("R10 no irq", 32'(irq), 0);
    rd(a_claim(0), d); check("R10 claim 0", d, 0);
    rd(A_PEND, d); check("R10 stays pending", d, 32'h80);
    wr(a_prio(7), 1);
    #1 check("R10 irq after priority", 32'(irq), 1);
    rd(a_claim(0), d); check("R10 claim", d, 7);
    wr(a_claim(0), 7);

    // R8/R9 in flight
    wr(A_PEND, 32'h8000);
    rd(a_claim(0), d); check("R8 claim 15", d, 15);
    wr(A_PEND, 32'h8000);
    rd(A_PEND, d); check("R8 re-pended", d, 32'h8000);
    check("R8 held back irq", 32'(irq), 0);
    rd(a_claim(0), d); check("R8 held back claim", d, 0);
    wr(a_claim(0), 23);
    #1 check("R9 wrong id ignored", 32'(irq), 0);
    wr(a_claim(0), 15);
    #1 check("R9 release", 32'(irq), 1);
    rd(a_claim(0), d); check("R9 reclaim", d, 15);
    wr(a_claim(0), 15);

    // R6 enable gating
    wr(a_en(1), 0);
    wr(A_PEND, pbit(2, 1));
    #1 check("R6 disabled", 32'(irq), 0);
    wr(a_en(1), 32'h40404040);
    #1 check("R6 enabled", 32'(irq), 32'b0010);
    rd(a_claim(1), d); check("R6 claim", d, 22);
    wr(a_claim(1), 22);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule